// File: doc/BRIEF.md
# IEEE-488 Parallel Port Bridge

This block is the glue between a small processor's parallel-port registers and an IEEE-488 instrument bus. The processor reads and writes a handful of byte-wide ports. The block turns them into bus drive and bus sense with the correct polarity. It carries the eight data lines and the eight management and handshake lines. It reports the disk controller's busy and direction flags and the device's configuration switches and bus address. It drives three active-low indicators. The handshake itself is run by firmware and is not part of this block.

Every bus line is active-low and is modelled as open-collector: the block only raises a per-line pull request (`*_pull` high pulls the line low), and it reads the resolved line level on a separate input. A register bit of 1 always means "asserted on the bus", so reads and writes are both inverted with respect to the bus level. The interface-clear line is sense-only. Its falling edge is passed through a three-state edge detector (IFC_IDLE, IFC_PULSE, IFC_HOLD). The detector produces a single-cycle local reset request:
- IFC_IDLE goes to IFC_PULSE when the registered line is seen active.
- IFC_PULSE goes to IFC_HOLD if the line is still active, or back to IFC_IDLE if it is not.
- IFC_HOLD returns to IFC_IDLE only when the line is released.

Top module: `gpib_port_bridge`

## Requirements
- R1: A read with `reg_sel`=0 returns `~dio_in` combinationally, so a bus data line held low reads as 1.
- R2: A write with `reg_sel`=0 sets `dio_pull` to the written byte from the next clock onward; a 1 bit pulls its data line low and a 0 bit releases it.
- R3: A read with `reg_sel`=1 returns `~ctl_in`, with lines in bit order 0..7: ATN, DAV, NDAC, NRFD, EOI, SRQ, REN, IFC.
- R4: A write with `reg_sel`=1 sets `ctl_pull[6:0]` to written bits 6..0 from the next clock onward, in the same bit order; `ctl_pull[7]` (IFC) is never asserted, whatever is written.
- R5: A read with `reg_sel`=2 returns `sw_n[0]` in bit 0, the bitwise inverse of the low three bits of (`dev_addr` − 8) in bits 3..1, and `sw_n[4:1]` in bits 7..4; `dev_addr` lies in 8..15.
- R6: A read with `reg_sel`=3 returns 1 in bit 4 when `dsk_busy` is 0, 1 in bit 5 when `dsk_dir` is 0, and 0 in every other bit.
- R7: A write with `reg_sel`=3 sets `led_n[2:0]` to written bits 2..0 from the next clock onward; an indicator is lit when its bit is 0.
- R8: When `ctl_in[7]` goes low before clock edge k, `rst_req` is high for exactly one cycle, from edge k+1 to edge k+2.
- R9: Holding `ctl_in[7]` low produces no further `rst_req` pulse; releasing it and pulling it low again produces exactly one new pulse.
- R10: After reset, `dio_pull` and `ctl_pull` are 0 (all lines released), `led_n` is 3'b111 (all indicators off), and `rst_req` is 0.
- R11: Writes with `reg_sel`=2 or 4..7 change none of `dio_pull`, `ctl_pull` and `led_n`; reads with `reg_sel`=4..7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Processor port select |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the selected port (combinational) |
| dio_in | input | 8 | Resolved bus data line levels |
| dio_pull | output | 8 | Per data line pull-low request |
| ctl_in | input | 8 | Resolved management/handshake line levels |
| ctl_pull | output | 8 | Per management line pull-low request, bit 7 always 0 |
| dev_addr | input | 5 | Primary bus address of the device (8..15) |
| sw_n | input | 5 | Active-low configuration switches |
| dsk_busy | input | 1 | Disk controller busy flag |
| dsk_dir | input | 1 | Disk controller direction flag |
| led_n | output | 3 | Active-low indicators |
| rst_req | output | 1 | One-cycle local reset request |

## Verification
The hardest situation to reach from the ports is the interface-clear line held low across many cycles and then re-armed. Random traffic on the control lines moves IFC too briefly and too often to show whether a held line re-triggers. The stimulus therefore parks IFC high long enough for the detector to settle in IFC_IDLE. It then pulls IFC low and samples `rst_req` on each of the following cycles to pin the pulse to its exact cycle. It keeps the line low for a long stretch while counting pulses, and finally releases and reasserts the line to show that the detector re-arms.

// File: rtl/gpib_bridge_pkg.sv
package gpib_bridge_pkg;

    localparam int BUS_LINES  = 8;
    localparam int LED_COUNT  = 3;
    localparam int SEL_W      = 3;

    // bit positions of the management lines inside the control ports
    localparam int LINE_ATN  = 0;
    localparam int LINE_DAV  = 1;
    localparam int LINE_NDAC = 2;
    localparam int LINE_NRFD = 3;
    localparam int LINE_EOI  = 4;
    localparam int LINE_SRQ  = 5;
    localparam int LINE_REN  = 6;
    localparam int LINE_IFC  = 7;

    typedef enum logic [SEL_W-1:0] {
        PSEL_DATA = 3'd0,
        PSEL_CTL  = 3'd1,
        PSEL_CFG  = 3'd2,
        PSEL_STAT = 3'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        IFC_IDLE  = 2'd0,
        IFC_PULSE = 2'd1,
        IFC_HOLD  = 2'd2
    } ifc_state_e;

endpackage

// File: rtl/gpib_out_regs.sv
module gpib_out_regs
    import gpib_bridge_pkg::*;
#(
    parameter int LINES = BUS_LINES,
    parameter int LEDS  = LED_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] dio_pull,
    output logic [LINES-1:0] ctl_pull,
    output logic [LEDS-1:0]  led_n
);

    localparam logic [LINES-1:0] LINES_RELEASED = '0;
    localparam logic [LEDS-1:0]  LEDS_DARK      = '1;

    logic [LINES-1:0] data_q;
    logic [LINES-1:0] ctl_q;
    logic [LEDS-1:0]  led_q;

    logic wr_data_port;
    logic wr_ctl_port;
    logic wr_led_port;

    always_comb begin
        wr_data_port = wr_en && (reg_sel == PSEL_DATA);
        wr_ctl_port  = wr_en && (reg_sel == PSEL_CTL);
        wr_led_port  = wr_en && (reg_sel == PSEL_STAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= LINES_RELEASED;
            ctl_q  <= LINES_RELEASED;
            led_q  <= LEDS_DARK;
        end else begin
            if (wr_data_port) data_q <= wr_data;
            if (wr_ctl_port)  ctl_q  <= wr_data;
            if (wr_led_port)  led_q  <= wr_data[LEDS-1:0];
        end
    end

    // a stored 1 means "asserted", which pulls the active-low line low
    assign dio_pull = data_q;

    // interface clear is sense-only: its drive is never connected
    for (genvar i = 0; i < LINES; i++) begin : g_ctl_drive
        if (i == LINE_IFC) begin : g_sense_only
            assign ctl_pull[i] = 1'b0;
        end else begin : g_driven
            assign ctl_pull[i] = ctl_q[i];
        end
    end

    assign led_n = led_q;

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == PSEL_DATA) |=> (dio_pull == $past(wr_data))); // R2

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == PSEL_CTL) |=> (ctl_pull == {1'b0, $past(wr_data[LINES-2:0])})); // R4

    AST_LED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == PSEL_STAT) |=> (led_n == $past(wr_data[LEDS-1:0]))); // R7

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (reg_sel == PSEL_DATA || reg_sel == PSEL_CTL || reg_sel == PSEL_STAT))
        |=> ($stable(dio_pull) && $stable(ctl_pull) && $stable(led_n))); // R11

endmodule

// File: rtl/gpib_rd_mux.sv
module gpib_rd_mux
    import gpib_bridge_pkg::*;
#(
    parameter int LINES     = BUS_LINES,
    parameter int ADDR_W    = 5,
    parameter int ADDR_BASE = 8
) (
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [LINES-1:0]  dio_in,
    input  logic [LINES-1:0]  ctl_in,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [4:0]        sw_n,
    input  logic              dsk_busy,
    input  logic              dsk_dir,
    output logic [LINES-1:0]  rd_data
);

    localparam int OFF_W = 3;

    logic [LINES-1:0] data_rd;
    logic [LINES-1:0] ctl_rd;
    logic [OFF_W-1:0] addr_off;
    logic [LINES-1:0] cfg_rd;
    logic [LINES-1:0] stat_rd;

    // each bus line reads as asserted (1) when its level is low
    for (genvar i = 0; i < LINES; i++) begin : g_sense
        assign data_rd[i] = ~dio_in[i];
        assign ctl_rd[i]  = ~ctl_in[i];
    end

    always_comb begin
        addr_off = OFF_W'(dev_addr - ADDR_W'(ADDR_BASE));
        cfg_rd   = {sw_n[4:1], ~addr_off, sw_n[0]};
        stat_rd  = {2'b00, ~dsk_dir, ~dsk_busy, 4'b0000};
    end

    always_comb begin
        unique case (reg_sel)
            PSEL_DATA: rd_data = data_rd;
            PSEL_CTL:  rd_data = ctl_rd;
            PSEL_CFG:  rd_data = cfg_rd;
            PSEL_STAT: rd_data = stat_rd;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpib_ifc_detect.sv
module gpib_ifc_detect
    import gpib_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ifc_line,
    output logic rst_req
);

    ifc_state_e state_q;
    ifc_state_e state_d;
    logic       ifc_q;
    logic       ifc_act;

    // one register stage on the bus level; reset value is "released"
    always_ff @(posedge clk) begin
        if (!rst_n) ifc_q <= 1'b1;
        else        ifc_q <= ifc_line;
    end

    assign ifc_act = ~ifc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IFC_IDLE:  if (ifc_act)  state_d = IFC_PULSE;
            IFC_PULSE: state_d = ifc_act ? IFC_HOLD : IFC_IDLE;
            IFC_HOLD:  if (!ifc_act) state_d = IFC_IDLE;
            default:   state_d = IFC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IFC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_req = (state_q == IFC_PULSE);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(ifc_act)); // R8

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(ifc_act, 2)); // R9

endmodule

// File: rtl/gpib_port_bridge.sv
module gpib_port_bridge
    import gpib_bridge_pkg::*;
#(
    parameter int LINES     = BUS_LINES,
    parameter int LEDS      = LED_COUNT,
    parameter int ADDR_W    = 5,
    parameter int ADDR_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [LINES-1:0]  wr_data,
    output logic [LINES-1:0]  rd_data,
    input  logic [LINES-1:0]  dio_in,
    output logic [LINES-1:0]  dio_pull,
    input  logic [LINES-1:0]  ctl_in,
    output logic [LINES-1:0]  ctl_pull,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [4:0]        sw_n,
    input  logic              dsk_busy,
    input  logic              dsk_dir,
    output logic [LEDS-1:0]   led_n,
    output logic              rst_req
);

    gpib_out_regs #(
        .LINES (LINES),
        .LEDS  (LEDS)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_sel  (reg_sel),
        .wr_data  (wr_data),
        .dio_pull (dio_pull),
        .ctl_pull (ctl_pull),
        .led_n    (led_n)
    );

    gpib_rd_mux #(
        .LINES     (LINES),
        .ADDR_W    (ADDR_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_rd (
        .reg_sel  (reg_sel),
        .dio_in   (dio_in),
        .ctl_in   (ctl_in),
        .dev_addr (dev_addr),
        .sw_n     (sw_n),
        .dsk_busy (dsk_busy),
        .dsk_dir  (dsk_dir),
        .rd_data  (rd_data)
    );

    gpib_ifc_detect u_ifc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ifc_line (ctl_in[LINE_IFC]),
        .rst_req  (rst_req)
    );

    AST_IFC_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_pull[LINE_IFC]); // R4

endmodule

// File: tb/gpib_port_bridge_tb_top.sv
module gpib_port_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_sel;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] dio_in;
    logic [7:0] dio_pull;
    logic [7:0] ctl_in;
    logic [7:0] ctl_pull;
    logic [4:0] dev_addr;
    logic [4:0] sw_n;
    logic       dsk_busy;
    logic       dsk_dir;
    logic [2:0] led_n;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_dio;
    logic [7:0] m_ctl;
    logic [2:0] m_led;

    always #4 clk = ~clk;

    gpib_port_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .dio_in(dio_in),
        .dio_pull(dio_pull), .ctl_in(ctl_in), .ctl_pull(ctl_pull),
        .dev_addr(dev_addr), .sw_n(sw_n), .dsk_busy(dsk_busy),
        .dsk_dir(dsk_dir), .led_n(led_n), .rst_req(rst_req)
    );

    function automatic logic [7:0] exp_cfg(input logic [4:0] a, input logic [4:0] s);
        logic [2:0] off = 3'(a - 5'd8);
        return {s[4:1], ~off, s[0]};
    endfunction

    function automatic logic [7:0] exp_stat(input logic b, input logic d);
        return {2'b00, ~d, ~b, 4'b0000};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " dio_pull"}, dio_pull, m_dio);
        chk({req, " ctl_pull"}, ctl_pull, m_ctl);
        chk({req, " led_n"}, {5'b0, led_n}, {5'b0, m_led});
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        int pulses;
        unused_seed = $urandom(32'h1f2e);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; reg_sel = '0;
        dio_in = 8'hFF; ctl_in = 8'hFF; dev_addr = 5'd8; sw_n = 5'h1F;
        dsk_busy = 1'b0; dsk_dir = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        m_dio = 8'h00; m_ctl = 8'h00; m_led = 3'b111;
        chk_outputs("R10");
        chk("R10 rst_req", {7'b0, rst_req}, 8'h00);

        // R1 R3 R5 R6: random reads across the four ports
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            dio_in   = 8'($urandom);
            ctl_in   = 8'($urandom);
            dev_addr = 5'(8 + ($urandom % 8));
            sw_n     = 5'($urandom);
            dsk_busy = 1'($urandom);
            dsk_dir  = 1'($urandom);
            reg_sel  = 3'($urandom % 4);
            #1;
            case (reg_sel)
                3'd0: chk("R1 data read", rd_data, ~dio_in);
                3'd1: chk("R3 ctl read", rd_data, ~ctl_in);
                3'd2: chk("R5 cfg read", rd_data, exp_cfg(dev_addr, sw_n));
                default: chk("R6 status read", rd_data, exp_stat(dsk_busy, dsk_dir));
            endcase
        end

        // directed: R3 single line order, ATN low -> bit0, IFC low -> bit7
        @(negedge clk); reg_sel = 3'd1; ctl_in = 8'hFE; #1;
        chk("R3 ATN bit0", rd_data, 8'h01);
        ctl_in = 8'h7F; #1;
        chk("R3 IFC bit7", rd_data, 8'h80);
        // directed: R5 address extremes
        reg_sel = 3'd2; sw_n = 5'h00; dev_addr = 5'd8; #1;
        chk("R5 addr 8", rd_data, 8'h0E);
        dev_addr = 5'd15; #1;
        chk("R5 addr 15", rd_data, 8'h00);
        ctl_in = 8'hFF;
        repeat (3) @(negedge clk);

        // R2 R4 R7: random writes
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d = 8'($urandom);
            case ($urandom % 3)
                0: begin do_write(3'd0, d); m_dio = d; end
                1: begin do_write(3'd1, d); m_ctl = {1'b0, d[6:0]}; end
                default: begin do_write(3'd3, d); m_led = d[2:0]; end
            endcase
            chk_outputs("R2/R4/R7 write");
        end

        // R4: IFC bit never driven even when written as 1
        do_write(3'd1, 8'hFF); m_ctl = 8'h7F;
        chk("R4 ctl all ones", ctl_pull, 8'h7F);
        // R2: zero releases every data line
        do_write(3'd0, 8'h00); m_dio = 8'h00;
        chk("R2 data release", dio_pull, 8'h00);
        // R7: indicators all lit
        do_write(3'd3, 8'hF8); m_led = 3'b000;
        chk("R7 leds lit", {5'b0, led_n}, 8'h00);

        // R11: writes to the config port and unused selects are ignored
        for (int i = 0; i < 12; i++) begin
            logic [2:0] s = (i % 5 == 0) ? 3'd2 : 3'(4 + ($urandom % 4));
            do_write(s, 8'($urandom));
            chk_outputs("R11 ignored write");
        end
        for (int s = 4; s < 8; s++) begin
            @(negedge clk); reg_sel = 3'(s); dio_in = 8'h00; #1;
            chk("R11 unused read", rd_data, 8'h00);
        end

        // R8: exact pulse timing after IFC falls
        @(negedge clk); ctl_in = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R8 quiet before", {7'b0, rst_req}, 8'h00);
        ctl_in[7] = 1'b0;
        @(negedge clk);
        chk("R8 cycle after edge k", {7'b0, rst_req}, 8'h00);
        @(negedge clk);
        chk("R8 pulse", {7'b0, rst_req}, 8'h01);
        @(negedge clk);
        chk("R8 pulse ends", {7'b0, rst_req}, 8'h00);

        // R9: held low gives no more pulses
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        chk("R9 held no retrigger", 8'(pulses), 8'd0);
        chk_outputs("R9 outputs kept");

        // R9: release and reassert re-arms, exactly one pulse
        ctl_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        ctl_in[7] = 1'b0;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        chk("R9 re-arm one pulse", 8'(pulses), 8'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule